// File: doc/BRIEF.md
# Prioritizing Bus Interrupt Requester

This block gathers four local device interrupt inputs and raises, for each one, one of seven system-bus interrupt request lines. Software programs the mapping. Each source has a control register that picks the request level (1 to 7), enables the source, selects the response mode, and holds a flag with optional auto-clear. Each source also has a separate vector register. A rising edge on an enabled device input sets that source's pending latch. The request line for the source's level stays high while any enabled pending source sits on that level.

When the bus acknowledges a level, the block looks for enabled pending sources at that level, and the lowest-numbered one wins. The block then answers in one of three ways:
- If the winner is in internal mode, the block drives the stored vector.
- If the winner is in external mode, the block pulses an acknowledge to that device and leaves vector supply to it.
- If no source qualifies, the block passes the daisy-chain acknowledge onward.

The acknowledge handler is a four-state machine. ACK_IDLE waits for an acknowledge strobe. From ACK_IDLE it moves to ACK_VECTOR when the winner is in internal mode, to ACK_EXTERNAL when the winner is in external mode, and to ACK_PASS when nothing qualifies. Each of these three response states lasts exactly one cycle and then returns to ACK_IDLE.

Top module: `bus_irq_requester`

## Requirements
- R1: After reset, `irq_req` is zero, every register reads zero, and `vec_valid`, `ext_ack` and `ack_out` are low.
- R2: Register addressing and control layout:
  - `reg_addr[2]`=0 selects control register `reg_addr[1:0]`; `reg_addr[2]`=1 selects vector register `reg_addr[1:0]`.
  - Control bits are: [2:0] level, [3] external mode, [4] enable, [5] flag, [6] flag auto-clear, [7] clear strobe.
  - Bit 7 is never stored and reads as 0. `reg_rdata` shows the addressed register combinationally.
- R3: Pending latch and request line:
  - A rising edge of `dev_int[n]` sets the pending latch of source n, but only while its enable bit is 1.
  - `irq_req[L-1]` is high while some source with enable=1 and level L is pending.
  - An edge seen while the source is disabled is not kept.
- R4: A source with level 0 drives no request line and never wins an acknowledge. An acknowledge of level 0 always passes on.
- R5: When several pending sources share a level, that level's line stays high until every one of them has been acknowledged.
- R6: Among eligible sources at the acknowledged level, the lowest-numbered input wins. The others stay pending.
- R7: Internal-mode response:
  - An accepted `ack_in` whose winner has external mode = 0 gives `vec_valid` high for one cycle, in the next cycle.
  - During that cycle `vec_out` equals the winner's vector register.
  - The winner's pending latch is cleared.
- R8: External-mode response: an accepted `ack_in` whose winner has external mode = 1 gives a one-cycle `ext_ack` pulse in the next cycle, with `ext_id` equal to the winner's index. `vec_valid` stays low and the winner's pending latch is cleared.
- R9: Pass-on response: an accepted `ack_in` with no eligible source gives a one-cycle `ack_out` pulse in the next cycle. No pending latch changes.
- R10: Response timing and exclusivity:
  - Each accepted `ack_in` yields exactly one of `vec_valid`, `ext_ack`, `ack_out`, for one cycle.
  - `ack_in` is accepted only while none of the three is high; it is ignored in the response cycle.
- R11: When a source wins an acknowledge and its auto-clear bit is 1, its flag bit is cleared. With auto-clear 0, the flag is kept.
- R12: Clearing and its collision rule:
  - Writing a control register with bit 7 = 1 clears that source's pending latch.
  - A new rising edge in the same cycle as a clear (by strobe or acknowledge) leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: bit 2 vector/control, bits 1:0 source |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of addressed register |
| dev_int | input | 4 | Local device interrupt inputs |
| irq_req | output | 7 | Bus request lines, bit L-1 is level L |
| ack_in | input | 1 | Acknowledge strobe / daisy-chain input |
| ack_level | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Stored vector is on `vec_out` |
| vec_out | output | 8 | Vector of winning internal-mode source |
| ext_ack | output | 1 | Acknowledge pulse to an external-mode device |
| ext_id | output | 2 | Index of the device receiving `ext_ack` |
| ack_out | output | 1 | Daisy-chain acknowledge passed on |

## Verification
The collision that matters is a fresh rising edge on a device input in the very cycle the acknowledge clears that same source's pending latch. The bench provokes it by dropping the input, then raising it again on the same clock that samples `ack_in`. It is judged by three observations: the vector still appears, the request line stays high afterwards, and a second acknowledge returns the vector again before the line falls. A second overlap is an `ack_in` held into the response cycle, which the scoreboard must see answered only once.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = (1 << LVL_W) - 1;
    localparam int CTRL_W  = 8;

    typedef struct packed {
        logic             autoclr;
        logic             flag;
        logic             en;
        logic             ext;
        logic [LVL_W-1:0] level;
    } ctrl_t;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_VECTOR,
        ACK_EXTERNAL,
        ACK_PASS
    } ack_state_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_req_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_vec,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dev_int,
    input  logic              take,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] vec,
    output logic              pending
);
    logic dev_q;
    logic set_pend;
    logic clr_pend;

    assign set_pend = dev_int & ~dev_q & ctrl.en;
    assign clr_pend = take | (wr_ctrl & wdata[CTRL_W-1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q   <= 1'b0;
            ctrl    <= '0;
            vec     <= '0;
            pending <= 1'b0;
        end else begin
            dev_q   <= dev_int;
            pending <= set_pend | (pending & ~clr_pend);
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(wdata[CTRL_W-2:0]);
            end else if (take && ctrl.autoclr) begin
                ctrl.flag <= 1'b0;
            end
            if (wr_vec) begin
                vec <= wdata;
            end
        end
    end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_req_pkg::*;
#(
    parameter int NUM_SRC = 4,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]            pend,
    input  logic [NUM_SRC-1:0]            en,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] level,
    input  logic [LVL_W-1:0]              ack_level,
    output logic [NUM_LVL-1:0]            irq_req,
    output logic                          found,
    output logic [IDX_W-1:0]              win_idx
);
    logic [NUM_SRC-1:0] elig;

    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
        logic [NUM_SRC-1:0] hit;
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign hit[n] = pend[n] & en[n] & (level[n] == LVL_W'(l));
        end
        assign irq_req[l-1] = |hit;
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_elig
        assign elig[n] = pend[n] & en[n] & (level[n] != '0) & (level[n] == ack_level);
    end

    assign found = |elig;

    always_comb begin
        win_idx = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (elig[n]) begin
                win_idx = IDX_W'(n);
            end
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_req_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_in,
    input  logic              found,
    input  logic              win_ext,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [DATA_W-1:0] win_vec,
    output logic              take,
    output logic              vec_valid,
    output logic [DATA_W-1:0] vec_out,
    output logic              ext_ack,
    output logic [IDX_W-1:0]  ext_id,
    output logic              ack_out
);
    ack_state_t        state;
    ack_state_t        state_nx;
    logic [DATA_W-1:0] vec_q;
    logic [IDX_W-1:0]  id_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ACK_IDLE: begin
                if (ack_in) begin
                    if (!found)       state_nx = ACK_PASS;
                    else if (win_ext) state_nx = ACK_EXTERNAL;
                    else              state_nx = ACK_VECTOR;
                end
            end
            ACK_VECTOR:   state_nx = ACK_IDLE;
            ACK_EXTERNAL: state_nx = ACK_IDLE;
            ACK_PASS:     state_nx = ACK_IDLE;
        endcase
    end

    assign take = (state == ACK_IDLE) && ack_in && found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ACK_IDLE;
            vec_q <= '0;
            id_q  <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                vec_q <= win_vec;
                id_q  <= win_idx;
            end
        end
    end

    always_comb begin
        vec_valid = 1'b0;
        ext_ack   = 1'b0;
        ack_out   = 1'b0;
        vec_out   = '0;
        ext_id    = '0;
        unique case (state)
            ACK_IDLE: ;
            ACK_VECTOR: begin
                vec_valid = 1'b1;
                vec_out   = vec_q;
            end
            ACK_EXTERNAL: begin
                ext_ack = 1'b1;
                ext_id  = id_q;
            end
            ACK_PASS: ack_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/bus_irq_requester.sv
module bus_irq_requester
    import irq_req_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] dev_int,
    output logic [NUM_LVL-1:0] irq_req,
    input  logic               ack_in,
    input  logic [LVL_W-1:0]   ack_level,
    output logic               vec_valid,
    output logic [DATA_W-1:0]  vec_out,
    output logic               ext_ack,
    output logic [IDX_W-1:0]   ext_id,
    output logic               ack_out
);
    ctrl_t                           ctrl   [NUM_SRC];
    logic [DATA_W-1:0]               vec    [NUM_SRC];
    logic [NUM_SRC-1:0]              pend;
    logic [NUM_SRC-1:0]              en_v;
    logic [NUM_SRC-1:0][LVL_W-1:0]   level_v;
    logic                            found;
    logic [IDX_W-1:0]                win_idx;
    logic                            take;
    logic [IDX_W-1:0]                sel;

    assign sel = reg_addr[IDX_W-1:0];

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_slot
        logic wr_c;
        logic wr_v;
        assign wr_c = reg_we && !reg_addr[IDX_W] && (sel == IDX_W'(n));
        assign wr_v = reg_we &&  reg_addr[IDX_W] && (sel == IDX_W'(n));
        irq_src_slot #(.DATA_W(DATA_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_c),
            .wr_vec  (wr_v),
            .wdata   (reg_wdata),
            .dev_int (dev_int[n]),
            .take    (take && (win_idx == IDX_W'(n))),
            .ctrl    (ctrl[n]),
            .vec     (vec[n]),
            .pending (pend[n])
        );
        assign en_v[n]    = ctrl[n].en;
        assign level_v[n] = ctrl[n].level;
    end

    irq_level_map #(.NUM_SRC(NUM_SRC)) u_map (
        .pend      (pend),
        .en        (en_v),
        .level     (level_v),
        .ack_level (ack_level),
        .irq_req   (irq_req),
        .found     (found),
        .win_idx   (win_idx)
    );

    irq_ack_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_in    (ack_in),
        .found     (found),
        .win_ext   (ctrl[win_idx].ext),
        .win_idx   (win_idx),
        .win_vec   (vec[win_idx]),
        .take      (take),
        .vec_valid (vec_valid),
        .vec_out   (vec_out),
        .ext_ack   (ext_ack),
        .ext_id    (ext_id),
        .ack_out   (ack_out)
    );

    always_comb begin
        if (reg_addr[IDX_W]) reg_rdata = vec[sel];
        else                 reg_rdata = DATA_W'({1'b0, ctrl[sel]});
    end
endmodule

// File: rtl/irq_req_checker.sv
module irq_req_checker
    import irq_req_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_LVL-1:0] irq_req,
    input logic               ack_in,
    input logic [LVL_W-1:0]   ack_level,
    input logic               vec_valid,
    input logic               ext_ack,
    input logic               ack_out
);
    logic       idle;
    logic [NUM_LVL:0] req_by_lvl;
    logic       lvl_hit;

    assign idle       = !(vec_valid || ext_ack || ack_out);
    assign req_by_lvl = {irq_req, 1'b0};
    assign lvl_hit    = req_by_lvl[ack_level];

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_valid, ext_ack, ack_out})); // R10
    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && idle) |=> ($countones({vec_valid, ext_ack, ack_out}) == 1)); // R10
    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> idle); // R10
    AST_PASS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && idle && !lvl_hit) |=> ack_out); // R9
    AST_LEVEL0_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && idle && (ack_level == '0)) |=> ack_out); // R4
    AST_REQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && idle && lvl_hit) |=> !ack_out); // R7
endmodule

bind bus_irq_requester irq_req_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .ack_in    (ack_in),
    .ack_level (ack_level),
    .vec_valid (vec_valid),
    .ext_ack   (ext_ack),
    .ack_out   (ack_out)
);

// File: tb/bus_irq_requester_test.sv
`timescale 1ns/1ps
module bus_irq_requester_test;
    localparam int KVEC = 1, KEXT = 2, KPASS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] dev_int = '0;
    logic [6:0] irq_req;
    logic       ack_in = 1'b0;
    logic [2:0] ack_level = '0;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic       ext_ack;
    logic [1:0] ext_id;
    logic       ack_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int    kind;
        int    data;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    bus_irq_requester uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_int(dev_int),
        .irq_req(irq_req), .ack_in(ack_in), .ack_level(ack_level),
        .vec_valid(vec_valid), .vec_out(vec_out), .ext_ack(ext_ack),
        .ext_id(ext_id), .ack_out(ack_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: pop expected responses as they appear
    always @(posedge clk) begin
        #1;
        if (rst_n && (vec_valid || ext_ack || ack_out)) begin
            int ak, ad;
            ak = vec_valid ? KVEC : (ext_ack ? KEXT : KPASS);
            ad = vec_valid ? int'(vec_out) : (ext_ack ? int'(ext_id) : 0);
            chk("R10 single response", int'(vec_valid) + int'(ext_ack) + int'(ack_out), 1);
            if (exp_q.size() == 0) begin
                chk("R10 unexpected response", ak, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, ak, e.kind);
                chk(e.req, ad, e.data);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic set_dev(input int n, input logic v);
        @(negedge clk);
        dev_int[n] = v;
        @(negedge clk);
    endtask

    task automatic pulse_dev(input int n);
        set_dev(n, 1'b0);
        set_dev(n, 1'b1);
    endtask

    task automatic do_ack(input logic [2:0] lvl, input int kind, input int data,
                          input string req, input int hold, input int raise_dev);
        exp_t e;
        e.kind = kind; e.data = data; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        ack_in = 1'b1; ack_level = lvl;
        if (raise_dev >= 0) dev_int[raise_dev] = 1'b1;
        for (int i = 0; i < hold; i++) @(negedge clk);
        ack_in = 1'b0;
    endtask

    task automatic req_chk(input int exp, input string req);
        @(negedge clk);
        chk(req, int'(irq_req), exp);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_req", int'(irq_req), 0);
        chk("R1 responses", int'({vec_valid, ext_ack, ack_out}), 0);
        rd_chk(3'd0, 0, "R1 ctrl0");
        rd_chk(3'd7, 0, "R1 vec3");

        // R2 / R3 / R7 / R9 single internal source at level 3
        wr(3'd4, 8'h40);
        wr(3'd0, 8'h13);
        rd_chk(3'd0, 8'h13, "R2 ctrl0 readback");
        rd_chk(3'd4, 8'h40, "R2 vec0 readback");
        set_dev(0, 1'b1);
        req_chk(7'h04, "R3 level3 request");
        do_ack(3'd4, KPASS, 0, "R9 other level passes", 1, -1);
        req_chk(7'h04, "R9 pending kept");
        do_ack(3'd3, KVEC, 8'h40, "R7 internal vector", 1, -1);
        req_chk(7'h00, "R7 pending cleared");

        // R5 / R6 / R8 shared level 5
        wr(3'd5, 8'h51);
        wr(3'd6, 8'h62);
        wr(3'd1, 8'h15);
        wr(3'd2, 8'h1D);
        @(negedge clk);
        dev_int[1] = 1'b1; dev_int[2] = 1'b1;
        @(negedge clk);
        req_chk(7'h10, "R5 shared line up");
        do_ack(3'd5, KVEC, 8'h51, "R6 lowest index wins", 1, -1);
        req_chk(7'h10, "R5 line held for sharer");
        do_ack(3'd5, KEXT, 2, "R8 external ack id", 1, -1);
        req_chk(7'h00, "R5 line drops after all");

        // R4 level zero
        wr(3'd3, 8'h10);
        set_dev(3, 1'b1);
        req_chk(7'h00, "R4 level0 no request");
        do_ack(3'd0, KPASS, 0, "R4 level0 passes", 1, -1);

        // R3 disabled edge not kept
        set_dev(0, 1'b0);
        wr(3'd0, 8'h03);
        set_dev(0, 1'b1);
        req_chk(7'h00, "R3 disabled no request");
        do_ack(3'd3, KPASS, 0, "R3 disabled not served", 1, -1);
        wr(3'd0, 8'h13);
        req_chk(7'h00, "R3 edge while disabled dropped");

        // R12 clear strobe
        pulse_dev(0);
        req_chk(7'h04, "R12 pending before clear");
        wr(3'd0, 8'h93);
        req_chk(7'h00, "R12 clear strobe");
        rd_chk(3'd0, 8'h13, "R2 bit7 reads zero");

        // R11 flag auto-clear
        wr(3'd0, 8'h73);
        wr(3'd1, 8'h35);
        pulse_dev(0);
        do_ack(3'd3, KVEC, 8'h40, "R11 ack src0", 1, -1);
        rd_chk(3'd0, 8'h53, "R11 flag auto-cleared");
        pulse_dev(1);
        do_ack(3'd5, KVEC, 8'h51, "R11 ack src1", 1, -1);
        rd_chk(3'd1, 8'h35, "R11 flag kept");

        // R12 new edge in the acknowledge cycle
        pulse_dev(0);
        set_dev(0, 1'b0);
        do_ack(3'd3, KVEC, 8'h40, "R12 collide ack", 1, 0);
        req_chk(7'h04, "R12 edge wins over ack clear");
        do_ack(3'd3, KVEC, 8'h40, "R12 second ack", 1, -1);
        req_chk(7'h00, "R12 line drops");

        // R10 held ack answered once
        pulse_dev(2);
        do_ack(3'd5, KEXT, 2, "R10 held ack", 2, -1);
        repeat (3) @(negedge clk);
        chk("R10 queue drained", exp_q.size(), 0);
        req_chk(7'h00, "R10 no second take");

        done = 1;
        report();
    end
endmodule